// File: doc/BRIEF.md
# Retry-or-Replace Recovery Sequencer for a Triplicated Unit

This sequencer supervises a unit built from three identical replicas and a majority voter. Whenever the voter reports that no two replicas agreed, the sequencer decides what to do next: run the task again on the same hardware, or give up on that hardware. Giving up means requesting a replacement and then a reload and restart. Most upsets are transient and clear when the task is simply run again, so the sequencer retries first. Every retry that fails makes a lasting fault more likely and makes the next retry less attractive. The sequencer therefore escalates to replacement once the failed retries pass a programmable limit, or once the accumulated cost of retrying would pass a programmable replacement cost.

The voter drives a strobe with a failure flag. The task logic drives a completion pulse. Three configuration inputs set the retry limit, the cost charged per retry and the cost at which replacement becomes the cheaper option. The outputs are three single-cycle request pulses and three status counters: failed retries in the current episode, accumulated retry cost, and the total number of replacements.

Top module: `tmr_recovery_ctrl`

## Requirements
- R1: After reset, all three request outputs are 0 and `fail_cnt`, `cost_sum` and `replace_total` are 0.
- R2: While idle, a voter strobe with the failure flag set (`vote_valid`=1, `vote_fail`=1) produces a `retry_req` pulse in the next cycle, unless R7 escalates.
- R3: Each request output is high for exactly one cycle, and at most one of the three is high in any cycle.
- R4: Every retry issued adds `cfg_retry_cost` to `cost_sum`, visible from the cycle after `retry_req`. Every failing strobe received while awaiting a retry's outcome increments `fail_cnt` by one.
- R5: While awaiting a retry's outcome, a `task_done` pulse without a failing strobe clears `fail_cnt` and `cost_sum`, returns to idle and issues no request.
- R6: A failing strobe while awaiting an outcome, which raises `fail_cnt` above `cfg_max_retries`, produces `replace_req` in the next cycle instead of `retry_req`.
- R7: A failure also produces `replace_req` in place of `retry_req` when `cost_sum + cfg_retry_cost > cfg_replace_cost`. This applies to the first failure of an episode too, where `cost_sum` is 0.
- R8: Each `replace_req` is followed in the next cycle by `restart_req`. The sequencer then returns to idle with `fail_cnt` and `cost_sum` at 0.
- R9: `replace_total` increments once per `replace_req` and saturates at 2^REP_W-1 (7 with defaults).
- R10: A failing strobe and `task_done` in the same cycle while awaiting an outcome count as a failure.
- R11: Strobes and `task_done` that arrive while a request is being issued are ignored. While idle, a passing strobe or a `task_done` has no effect on requests or counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vote_valid | input | 1 | Voter result strobe |
| vote_fail | input | 1 | With strobe: no majority reached |
| task_done | input | 1 | Task completion pulse |
| cfg_max_retries | input | CNT_W | Failed retries tolerated before replacement |
| cfg_retry_cost | input | COST_W | Cost charged per retry |
| cfg_replace_cost | input | SUM_W | Cost at which replacement is preferred |
| retry_req | output | 1 | Pulse: re-execute the task |
| replace_req | output | 1 | Pulse: replace the hardware |
| restart_req | output | 1 | Pulse: reload and restart |
| fail_cnt | output | CNT_W+1 | Failed retries in the current episode |
| cost_sum | output | SUM_W | Accumulated retry cost of the episode |
| replace_total | output | REP_W | Saturating count of replacements |

## Verification
Two functions can fall in the same cycle: the completion pulse that ends an episode successfully, and a failing voter strobe that continues it. The bench drives both edges in one cycle while a retry's outcome is pending. It judges the result by the request that follows: a further retry, not a return to idle. It also checks that `fail_cnt` has risen rather than been cleared. A strobe held across the request cycle exercises the second overlap, where a new failure arrives while a retry is still being issued. That strobe must yield exactly one request.

// File: rtl/tmr_rcv_pkg.sv
package tmr_rcv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RETRY   = 3'd1,
        ST_WAIT    = 3'd2,
        ST_REPLACE = 3'd3,
        ST_RESTART = 3'd4
    } rcv_state_e;

endpackage

// File: rtl/rcv_escalate_judge.sv
// Decides between another retry and replacement; also forms the
// saturated cost after one more retry.
module rcv_escalate_judge #(
    parameter int CNT_W  = 4,
    parameter int COST_W = 8,
    parameter int SUM_W  = 13
) (
    input  logic [CNT_W:0]    fails_after,
    input  logic [CNT_W-1:0]  max_retries,
    input  logic [SUM_W-1:0]  cost_now,
    input  logic [COST_W-1:0] retry_cost,
    input  logic [SUM_W-1:0]  replace_cost,
    output logic [SUM_W-1:0]  cost_after,
    output logic              escalate
);
    localparam int EXT_W = SUM_W + 1;

    logic [EXT_W-1:0] cost_ext;
    logic             too_many;
    logic             too_costly;

    always_comb begin
        cost_ext   = {1'b0, cost_now} + EXT_W'(retry_cost);
        too_many   = fails_after > {1'b0, max_retries};
        too_costly = cost_ext > {1'b0, replace_cost};
        escalate   = too_many | too_costly;
        if (cost_ext[EXT_W-1]) begin
            cost_after = '1;
        end else begin
            cost_after = cost_ext[SUM_W-1:0];
        end
    end
endmodule

// File: rtl/rcv_sat_ctr.sv
module rcv_sat_ctr #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] count_d;
    logic [W-1:0] count_q;

    always_comb begin
        count_d = count_q;
        if (inc && (count_q != TOP)) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

    AST_REP_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == TOP) |=> (count_q == TOP)); // R9
    AST_REP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count_q != TOP) |=> (count_q == $past(count_q) + 1'b1)); // R9
endmodule

// File: rtl/tmr_recovery_ctrl.sv
module tmr_recovery_ctrl
    import tmr_rcv_pkg::*;
#(
    parameter  int CNT_W  = 4,
    parameter  int COST_W = 8,
    parameter  int REP_W  = 3,
    localparam int SUM_W  = COST_W + CNT_W + 1,
    localparam int FAIL_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vote_valid,
    input  logic              vote_fail,
    input  logic              task_done,
    input  logic [CNT_W-1:0]  cfg_max_retries,
    input  logic [COST_W-1:0] cfg_retry_cost,
    input  logic [SUM_W-1:0]  cfg_replace_cost,
    output logic              retry_req,
    output logic              replace_req,
    output logic              restart_req,
    output logic [FAIL_W-1:0] fail_cnt,
    output logic [SUM_W-1:0]  cost_sum,
    output logic [REP_W-1:0]  replace_total
);
    typedef struct packed {
        rcv_state_e        state;
        logic [FAIL_W-1:0] fails;
        logic [SUM_W-1:0]  cost;
    } rcv_regs_t;

    localparam logic [FAIL_W-1:0] FAIL_TOP = '1;

    rcv_regs_t r_d;
    rcv_regs_t r_q;

    logic              fail_seen;
    logic [FAIL_W-1:0] fails_inc;
    logic [FAIL_W-1:0] fails_judged;
    logic [SUM_W-1:0]  cost_after;
    logic              escalate;

    always_comb begin
        fail_seen = vote_valid & vote_fail;
        if (r_q.fails == FAIL_TOP) begin
            fails_inc = r_q.fails;
        end else begin
            fails_inc = r_q.fails + 1'b1;
        end
        fails_judged = (r_q.state == ST_WAIT) ? fails_inc : r_q.fails;
    end

    rcv_escalate_judge #(
        .CNT_W (CNT_W),
        .COST_W(COST_W),
        .SUM_W (SUM_W)
    ) u_judge (
        .fails_after (fails_judged),
        .max_retries (cfg_max_retries),
        .cost_now    (r_q.cost),
        .retry_cost  (cfg_retry_cost),
        .replace_cost(cfg_replace_cost),
        .cost_after  (cost_after),
        .escalate    (escalate)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (fail_seen) begin
                    r_d.state = escalate ? ST_REPLACE : ST_RETRY;
                end
            end
            ST_RETRY: begin
                r_d.cost  = cost_after;
                r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (fail_seen) begin
                    r_d.fails = fails_inc;
                    r_d.state = escalate ? ST_REPLACE : ST_RETRY;
                end else if (task_done) begin
                    r_d.fails = '0;
                    r_d.cost  = '0;
                    r_d.state = ST_IDLE;
                end
            end
            ST_REPLACE: begin
                r_d.fails = '0;
                r_d.cost  = '0;
                r_d.state = ST_RESTART;
            end
            ST_RESTART: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.fails <= '0;
            r_q.cost  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    rcv_sat_ctr #(
        .W(REP_W)
    ) u_rep_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (r_q.state == ST_REPLACE),
        .count(replace_total)
    );

    assign retry_req   = (r_q.state == ST_RETRY);
    assign replace_req = (r_q.state == ST_REPLACE);
    assign restart_req = (r_q.state == ST_RESTART);
    assign fail_cnt    = r_q.fails;
    assign cost_sum    = r_q.cost;

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retry_req, replace_req, restart_req})); // R3
    AST_RETRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |=> !retry_req); // R3
    AST_RESTART_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        replace_req |=> (restart_req && fail_cnt == '0 && cost_sum == '0)); // R8
    AST_CLEAR_ON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && task_done && !(vote_valid && vote_fail))
        |=> (fail_cnt == '0 && cost_sum == '0 && !retry_req && !replace_req)); // R5
    AST_FAIL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && vote_valid && vote_fail && task_done)
        |=> (retry_req || replace_req)); // R10
    AST_COST_CHARGED: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |=> (cost_sum >= $past(cost_sum))); // R4
endmodule

// File: tb/tmr_recovery_ctrl_test.sv
module tmr_recovery_ctrl_test;
    localparam int CNT_W  = 4;
    localparam int COST_W = 8;
    localparam int REP_W  = 3;
    localparam int SUM_W  = COST_W + CNT_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vote_valid = 1'b0;
    logic vote_fail = 1'b0;
    logic task_done = 1'b0;
    logic [CNT_W-1:0]  cfg_max_retries = '0;
    logic [COST_W-1:0] cfg_retry_cost = '0;
    logic [SUM_W-1:0]  cfg_replace_cost = '0;
    logic retry_req, replace_req, restart_req;
    logic [CNT_W:0]   fail_cnt;
    logic [SUM_W-1:0] cost_sum;
    logic [REP_W-1:0] replace_total;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    int exp_q[$];
    int prev_kind = 0;

    always #4 clk = ~clk;

    tmr_recovery_ctrl #(.CNT_W(CNT_W), .COST_W(COST_W), .REP_W(REP_W)) uut (
        .clk(clk), .rst_n(rst_n), .vote_valid(vote_valid), .vote_fail(vote_fail),
        .task_done(task_done), .cfg_max_retries(cfg_max_retries),
        .cfg_retry_cost(cfg_retry_cost), .cfg_replace_cost(cfg_replace_cost),
        .retry_req(retry_req), .replace_req(replace_req), .restart_req(restart_req),
        .fail_cnt(fail_cnt), .cost_sum(cost_sum), .replace_total(replace_total)
    );

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // kind codes: 1 retry, 2 replace, 3 restart
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int kind;
            kind = 0;
            if (retry_req)   kind = 1;
            if (replace_req) kind = 2;
            if (restart_req) kind = 3;
            if (retry_req + replace_req + restart_req > 1)
                check_eq("R3 requests at once", retry_req + replace_req + restart_req, 1);
            if (kind != 0) begin
                if (kind == prev_kind) check_eq("R3 pulse width", 2, 1);
                if (exp_q.size() == 0) begin
                    check_eq("R11 unexpected request", kind, 0);
                end else begin
                    check_eq("R2/R6/R7/R8 request order", kind, exp_q.pop_front());
                end
            end
            prev_kind = kind;
        end
    end

    task automatic expect_req(int kind);
        exp_q.push_back(kind);
    endtask

    task automatic strobe(bit fl, bit done, int hold);
        @(negedge clk);
        vote_valid = 1'b1;
        vote_fail = fl;
        task_done = done;
        repeat (hold) @(negedge clk);
        vote_valid = 1'b0;
        vote_fail = 1'b0;
        task_done = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic done_only();
        @(negedge clk);
        task_done = 1'b1;
        @(negedge clk);
        task_done = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic drained(string tag);
        check_eq(tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1 retry_req reset", retry_req, 0);
        check_eq("R1 replace_req reset", replace_req, 0);
        check_eq("R1 restart_req reset", restart_req, 0);
        check_eq("R1 counters reset", fail_cnt + cost_sum + replace_total, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11: idle ignores passing strobe and task_done
        cfg_max_retries = 4'd2; cfg_retry_cost = 8'd10; cfg_replace_cost = 13'd100;
        strobe(1'b0, 1'b0, 1);
        done_only();
        check_eq("R11 idle counters", fail_cnt + cost_sum + replace_total, 0);

        // R2/R4/R6: retries until limit exceeded
        expect_req(1); strobe(1'b1, 1'b0, 1);
        check_eq("R4 cost after first retry", cost_sum, 10);
        check_eq("R4 fail_cnt first retry", fail_cnt, 0);
        expect_req(1); strobe(1'b1, 1'b0, 1);
        check_eq("R4 fail_cnt", fail_cnt, 1);
        check_eq("R4 cost", cost_sum, 20);
        expect_req(1); strobe(1'b1, 1'b0, 1);
        check_eq("R4 fail_cnt second", fail_cnt, 2);
        expect_req(2); expect_req(3); strobe(1'b1, 1'b0, 1);
        drained("R6 replace after limit");
        check_eq("R8 cleared fail_cnt", fail_cnt, 0);
        check_eq("R8 cleared cost", cost_sum, 0);
        check_eq("R9 replace_total", replace_total, 1);

        // R5: success clears
        expect_req(1); strobe(1'b1, 1'b0, 1);
        expect_req(1); strobe(1'b1, 1'b0, 1);
        done_only();
        drained("R5 no extra request");
        check_eq("R5 fail_cnt cleared", fail_cnt, 0);
        check_eq("R5 cost cleared", cost_sum, 0);

        // R7: cost-driven escalation
        cfg_max_retries = 4'd10; cfg_retry_cost = 8'd40;
        expect_req(1); strobe(1'b1, 1'b0, 1);
        expect_req(1); strobe(1'b1, 1'b0, 1);
        check_eq("R7 cost 80", cost_sum, 80);
        expect_req(2); expect_req(3); strobe(1'b1, 1'b0, 1);
        drained("R7 replace on cost");
        check_eq("R9 replace_total 2", replace_total, 2);

        // R10: failure and completion together
        cfg_retry_cost = 8'd5;
        expect_req(1); strobe(1'b1, 1'b0, 1);
        expect_req(1); strobe(1'b1, 1'b1, 1);
        drained("R10 fail wins");
        check_eq("R10 fail_cnt", fail_cnt, 1);
        check_eq("R10 cost", cost_sum, 10);
        done_only();

        // R11: strobe held across request cycle gives one request
        expect_req(1); strobe(1'b1, 1'b0, 2);
        drained("R11 held strobe");
        check_eq("R11 cost single charge", cost_sum, 5);
        done_only();

        // R7 first failure, and R9 saturation
        cfg_retry_cost = 8'd200;
        for (int i = 0; i < 7; i++) begin
            expect_req(2); expect_req(3); strobe(1'b1, 1'b0, 1);
        end
        drained("R7 immediate replace");
        check_eq("R9 saturated", replace_total, 7);
        check_eq("R8 idle counters", fail_cnt + cost_sum, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule